// File: doc/BRIEF.md
# Vector Load/Store Element Address Sequencer

This block turns one vector memory command into a series of per-element memory requests. A command names a base address value, a signed immediate offset, a stride value, an addressing mode, an element size and a vector length. The sequencer then issues one request per element. Each request carries the byte address, the access size and the register number that the element belongs to. The register number starts at the command's destination and goes up by one for each element, so a command acts as a load-multiple or store-multiple over consecutive registers.

The same scalar encoding covers all three addressing modes, so no separate vector opcode is needed. The modes are: consecutive elements packed at the access size, elements spaced by an explicit stride, and an index value added for each element.

The block also takes a 16-bit compact command word and expands it into the same internal request. In that form, one offset bit becomes a stride-enable flag and the access size comes from the function code. The indexed mode cannot be expressed in the compact form, because it has no room for an index operand.

The memory access itself, translation faults and the register write-back all sit outside this block.

Top module: `vls_addr_gen`

## Requirements
- R1: `cmd_ready` is 1 exactly when the block is idle, meaning no element is outstanding and `done` is low. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1.
- R2: In full form with `cmd_mode`=01 (strided), element j has address `cmd_base` + sign-extended `cmd_offset` + j*`cmd_stride`, modulo 2^ADDR_W. A negative stride counts downward.
- R3: In full form with `cmd_mode`=00 (unit), the step between elements is 2^size bytes and `cmd_stride` is ignored. The reserved mode 11 behaves the same as unit.
- R4: In full form with `cmd_mode`=10 (indexed), the address of the presented element is `cmd_base` + sign-extended `cmd_offset` + `idx_value`. `idx_value` is read combinationally while the request is presented, and `req_elem` gives that element's number j.
- R5: `req_size` is log2 of the access bytes. In full form it equals `cmd_size`, except that codes 5 to 7 read as 4. `req_reg` for element j is the destination register plus j, modulo 2^REG_W.
- R6: In compact form (`cmd_is_c`=1), the fields of `cmd_cinsn` are decoded as follows:
  - The offset is {c[12:10], c[6], 2'b00}, zero-extended.
  - c[5]=1 selects strided mode with `cmd_stride`; c[5]=0 selects unit mode.
  - The destination register is 8 + c[4:2].
  - `cmd_mode`, `cmd_offset`, `cmd_size`, `cmd_dest` and bits c[9:7] and c[1:0] have no effect.
- R7: In compact form, the size comes from c[15:13]:
  - 000 gives 4-byte floating single.
  - 001 gives 8-byte floating double.
  - 010 gives 4-byte word.
  - 011 gives 8-byte double.
  - 100 gives 16-byte quad.
  - 101, 110 and 111 give 4 bytes.
- R8: Exactly `cmd_vlen` requests are issued, with `req_elem` counting 0, 1, 2 and so on. While `req_valid` is 1 and `req_ready` is 0, the request holds its element number, register, size and (in non-indexed modes) its address.
- R9: `done` is high for one cycle, in the cycle after the last element's handshake. `cmd_ready` returns in the cycle after that.
- R10: A command with `cmd_vlen`=0 issues no request, and `done` rises in the cycle after the command is taken.
- R11: Command inputs presented while a command is in progress have no effect on the requests still to be issued.
- R12: An asynchronous reset forces `cmd_ready`=1, `req_valid`=0 and `done`=0, including in the middle of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_is_c | input | 1 | 1 selects the compact command word |
| cmd_cinsn | input | 16 | Compact command word |
| cmd_mode | input | 2 | Full-form mode: 00 unit, 01 strided, 10 indexed, 11 as unit |
| cmd_size | input | 3 | Full-form log2 access bytes |
| cmd_offset | input | OFF_W | Full-form signed immediate offset |
| cmd_dest | input | REG_W | Full-form first register number |
| cmd_base | input | ADDR_W | Base address value |
| cmd_stride | input | ADDR_W | Stride in bytes (two's complement) |
| cmd_vlen | input | VL_W | Number of elements |
| idx_value | input | ADDR_W | Index offset for the presented element (indexed mode) |
| req_valid | output | 1 | Element request presented |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | ADDR_W | Element byte address |
| req_size | output | 3 | log2 of access bytes |
| req_reg | output | REG_W | Register number of the element |
| req_elem | output | VL_W | Element number j |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to bring about from the ports is a command arriving while a request is stalled. Only then can the bench show that the running address, register number and element count are neither disturbed by the new command nor advanced by the stall. The stimulus holds `req_ready` low on every odd element. In one run it also keeps `cmd_valid` high with unrelated fields for the whole command. The requests must then keep following the first command's arithmetic. A register-number wrap past 31 and a negative stride are placed in the same stalled runs, so that a wrong carry into the accumulators shows up as an address mismatch.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic [1:0] {
    MODE_UNIT   = 2'b00,
    MODE_STRIDE = 2'b01,
    MODE_INDEX  = 2'b10,
    MODE_RSVD   = 2'b11
  } vls_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } vls_state_e;

  localparam logic [2:0] MAX_SIZE = 3'd4;

  function automatic logic [2:0] clamp_size(input logic [2:0] s);
    return (s > MAX_SIZE) ? MAX_SIZE : s;
  endfunction

  function automatic logic [2:0] compact_size(input logic [2:0] f3);
    logic [2:0] r;
    case (f3)
      3'b000:  r = 3'd2;
      3'b001:  r = 3'd3;
      3'b010:  r = 3'd2;
      3'b011:  r = 3'd3;
      3'b100:  r = 3'd4;
      default: r = 3'd2;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vls_cdecode.sv
module vls_cdecode
  import vls_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int REG_W = 5
) (
  input  logic             is_c,
  input  logic [15:0]      cinsn,
  input  vls_mode_e        full_mode,
  input  logic [2:0]       full_size,
  input  logic [OFF_W-1:0] full_off,
  input  logic [REG_W-1:0] full_dest,
  output vls_mode_e        eff_mode,
  output logic [2:0]       eff_size,
  output logic [OFF_W-1:0] eff_off,
  output logic [REG_W-1:0] eff_dest
);

  localparam int COFF_W = 6;

  logic [COFF_W-1:0] c_off;
  logic              unused_cbits;

  assign c_off        = {cinsn[12:10], cinsn[6], 2'b00};
  assign unused_cbits = ^{cinsn[9:7], cinsn[1:0]};

  always_comb begin
    if (is_c) begin
      eff_mode = cinsn[5] ? MODE_STRIDE : MODE_UNIT;
      eff_size = compact_size(cinsn[15:13]);
      eff_off  = OFF_W'(c_off);
      eff_dest = REG_W'(4'd8) + REG_W'(cinsn[4:2]);
    end else begin
      eff_mode = full_mode;
      eff_size = clamp_size(full_size);
      eff_off  = full_off;
      eff_dest = full_dest;
    end
  end

endmodule

// File: rtl/vls_seq.sv
module vls_seq
  import vls_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_fire,
  input  logic [VL_W-1:0] cmd_vlen,
  input  logic            req_ready,
  output logic            idle,
  output logic            running,
  output logic            fin,
  output logic [VL_W-1:0] elem,
  output logic            step_en
);

  vls_state_e      state_q, state_d;
  logic [VL_W-1:0] elem_q, elem_d;
  logic [VL_W-1:0] vlen_q;
  logic            elem_en, vlen_en, last;

  assign last = (elem_q == VL_W'(vlen_q - 1'b1));

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    elem_en = 1'b0;
    vlen_en = 1'b0;
    step_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_fire) begin
          vlen_en = 1'b1;
          elem_en = 1'b1;
          elem_d  = '0;
          state_d = (cmd_vlen == '0) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (req_ready) begin
          if (last) begin
            state_d = ST_FIN;
          end else begin
            elem_en = 1'b1;
            elem_d  = elem_q + 1'b1;
            step_en = 1'b1;
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       elem_q <= '0;
    else if (elem_en) elem_q <= elem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vlen_q <= '0;
    else if (vlen_en) vlen_q <= cmd_vlen;
  end

  assign idle    = (state_q == ST_IDLE);
  assign running = (state_q == ST_RUN);
  assign fin     = (state_q == ST_FIN);
  assign elem    = elem_q;

endmodule

// File: rtl/vls_agen.sv
module vls_agen
  import vls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [ADDR_W-1:0] ld_stride,
  input  vls_mode_e         ld_mode,
  input  logic [2:0]        ld_size,
  input  logic [REG_W-1:0]  ld_dest,
  input  logic [ADDR_W-1:0] idx_value,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        size,
  output logic [REG_W-1:0]  regnum
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] boff_q, boff_d;
  logic [ADDR_W-1:0] run_q, run_d;
  logic [ADDR_W-1:0] step_q, step_d;
  vls_mode_e         mode_q;
  logic [2:0]        size_q;
  logic [REG_W-1:0]  reg_q, reg_d;
  logic              upd_en;

  generate
    if (ADDR_W > OFF_W) begin : g_sext
      assign off_ext = {{(ADDR_W - OFF_W){ld_off[OFF_W-1]}}, ld_off};
    end else begin : g_trunc
      assign off_ext = ld_off[ADDR_W-1:0];
    end
  endgenerate

  assign upd_en = load | step;

  always_comb begin
    boff_d = boff_q;
    step_d = step_q;
    run_d  = run_q;
    reg_d  = reg_q;
    if (load) begin
      boff_d = ld_base + off_ext;
      run_d  = ld_base + off_ext;
      step_d = (ld_mode == MODE_STRIDE) ? ld_stride : (ONE << ld_size);
      reg_d  = ld_dest;
    end else if (step) begin
      run_d  = run_q + step_q;
      reg_d  = reg_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boff_q <= '0;
      step_q <= '0;
      mode_q <= MODE_UNIT;
      size_q <= '0;
    end else if (load) begin
      boff_q <= boff_d;
      step_q <= step_d;
      mode_q <= ld_mode;
      size_q <= ld_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      reg_q <= '0;
    end else if (upd_en) begin
      run_q <= run_d;
      reg_q <= reg_d;
    end
  end

  assign addr   = (mode_q == MODE_INDEX) ? (boff_q + idx_value) : run_q;
  assign size   = size_q;
  assign regnum = reg_q;

endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
  import vls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int REG_W  = 5,
  parameter int VL_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_is_c,
  input  logic [15:0]       cmd_cinsn,
  input  logic [1:0]        cmd_mode,
  input  logic [2:0]        cmd_size,
  input  logic [OFF_W-1:0]  cmd_offset,
  input  logic [REG_W-1:0]  cmd_dest,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] cmd_stride,
  input  logic [VL_W-1:0]   cmd_vlen,
  input  logic [ADDR_W-1:0] idx_value,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [2:0]        req_size,
  output logic [REG_W-1:0]  req_reg,
  output logic [VL_W-1:0]   req_elem,
  output logic              done
);

  vls_mode_e        dec_mode;
  logic [2:0]       dec_size;
  logic [OFF_W-1:0] dec_off;
  logic [REG_W-1:0] dec_dest;
  logic             idle, running, fin, step_en, cmd_fire;

  assign cmd_fire = cmd_valid & idle;

  vls_cdecode #(.OFF_W(OFF_W), .REG_W(REG_W)) u_dec (
    .is_c      (cmd_is_c),
    .cinsn     (cmd_cinsn),
    .full_mode (vls_mode_e'(cmd_mode)),
    .full_size (cmd_size),
    .full_off  (cmd_offset),
    .full_dest (cmd_dest),
    .eff_mode  (dec_mode),
    .eff_size  (dec_size),
    .eff_off   (dec_off),
    .eff_dest  (dec_dest)
  );

  vls_seq #(.VL_W(VL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_fire  (cmd_fire),
    .cmd_vlen  (cmd_vlen),
    .req_ready (req_ready),
    .idle      (idle),
    .running   (running),
    .fin       (fin),
    .elem      (req_elem),
    .step_en   (step_en)
  );

  vls_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .REG_W(REG_W)) u_agen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_fire),
    .step      (step_en),
    .ld_base   (cmd_base),
    .ld_off    (dec_off),
    .ld_stride (cmd_stride),
    .ld_mode   (dec_mode),
    .ld_size   (dec_size),
    .ld_dest   (dec_dest),
    .idx_value (idx_value),
    .addr      (req_addr),
    .size      (req_size),
    .regnum    (req_reg)
  );

  assign cmd_ready = idle;
  assign req_valid = running;
  assign done      = fin;

endmodule

// File: rtl/vls_addr_gen_chk.sv
module vls_addr_gen_chk #(
  parameter int REG_W = 5,
  parameter int VL_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [VL_W-1:0]  cmd_vlen,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VL_W-1:0]  req_elem,
  input logic [REG_W-1:0] req_reg,
  input logic [2:0]       req_size,
  input logic             done
);

  // R1: ready only while nothing is outstanding
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!req_valid && !done));

  // R8: a stalled request holds its payload
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_elem) && $stable(req_reg) && $stable(req_size)));

  // R5: element and register numbers advance by one per handshake
  p_elem_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (!req_valid || (req_elem == VL_W'($past(req_elem) + 1'b1)
                      && req_reg == REG_W'($past(req_reg) + 1'b1))));

  // R9: done lasts one cycle and is followed by ready
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));

  // R10: done only after a final handshake or an empty command
  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(req_valid && req_ready)
              || $past(cmd_valid && cmd_ready && (cmd_vlen == '0))));

endmodule

bind vls_addr_gen vls_addr_gen_chk #(.REG_W(REG_W), .VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_vlen  (cmd_vlen),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_elem  (req_elem),
  .req_reg   (req_reg),
  .req_size  (req_size),
  .done      (done)
);

// File: tb/sim_vls_addr_gen.sv
module sim_vls_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic        is_c;
    logic [15:0] cinsn;
    logic [1:0]  mode;
    logic [2:0]  size;
    logic [11:0] off;
    logic [4:0]  dest;
    logic [31:0] base;
    logic [31:0] stride;
    logic [6:0]  vlen;
  } vec_t;

  // is_c, cinsn, mode, size, off, dest, base, stride, vlen
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0000, 2'b00, 3'd2, 12'h010, 5'd3,  32'h0000_1000, 32'h0000_0055, 7'd4}, // R3 unit 4B
    '{1'b0, 16'h0000, 2'b01, 3'd3, 12'hFF8, 5'd30, 32'h0000_2000, 32'h0000_0040, 7'd5}, // R2 R5 wrap
    '{1'b0, 16'h0000, 2'b10, 3'd1, 12'h004, 5'd0,  32'h0000_8000, 32'h0000_0000, 7'd3}, // R4 indexed
    '{1'b0, 16'h0000, 2'b01, 3'd0, 12'h000, 5'd7,  32'h0000_0100, 32'hFFFF_FFF0, 7'd3}, // R2 neg stride
    '{1'b0, 16'h0000, 2'b11, 3'd7, 12'h000, 5'd1,  32'h0000_0000, 32'h0000_0009, 7'd2}, // R3 R5 rsvd/clamp
    '{1'b1, 16'h544C, 2'b10, 3'd0, 12'h7FF, 5'd2,  32'h0000_3000, 32'h0000_0777, 7'd3}, // R6 R7 word unit
    '{1'b1, 16'h8D3C, 2'b00, 3'd1, 12'h800, 5'd4,  32'h0000_4000, 32'h0000_0100, 7'd4}, // R6 R7 quad stride
    '{1'b1, 16'h2000, 2'b01, 3'd0, 12'h100, 5'd9,  32'h0000_5000, 32'h0000_0300, 7'd2}, // R7 fp double
    '{1'b1, 16'hFFDC, 2'b00, 3'd4, 12'h000, 5'd0,  32'h0000_6000, 32'h0000_0010, 7'd2}, // R7 rsvd f3
    '{1'b1, 16'h6000, 2'b00, 3'd0, 12'h000, 5'd0,  32'h0000_7000, 32'h0000_0000, 7'd2}, // R7 double
    '{1'b1, 16'h0000, 2'b00, 3'd4, 12'h000, 5'd0,  32'h0000_7100, 32'h0000_0000, 7'd1}  // R7 fp single
  };

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready, cmd_is_c;
  logic [15:0] cmd_cinsn;
  logic [1:0]  cmd_mode;
  logic [2:0]  cmd_size;
  logic [11:0] cmd_offset;
  logic [4:0]  cmd_dest;
  logic [31:0] cmd_base, cmd_stride, idx_value;
  logic [6:0]  cmd_vlen;
  logic        req_valid, req_ready, done;
  logic [31:0] req_addr;
  logic [2:0]  req_size;
  logic [4:0]  req_reg;
  logic [6:0]  req_elem;

  int n_chk = 0;
  int n_err = 0;

  vls_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_c(cmd_is_c), .cmd_cinsn(cmd_cinsn), .cmd_mode(cmd_mode),
    .cmd_size(cmd_size), .cmd_offset(cmd_offset), .cmd_dest(cmd_dest),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_vlen(cmd_vlen),
    .idx_value(idx_value), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_reg(req_reg),
    .req_elem(req_elem), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] idx_of(input int j);
    return 32'h100 + 32'(j * j * 12);
  endfunction

  function automatic logic [2:0] exp_size(input vec_t v);
    if (v.is_c) begin
      case (v.cinsn[15:13])
        3'b000: return 3'd2;
        3'b001: return 3'd3;
        3'b010: return 3'd2;
        3'b011: return 3'd3;
        3'b100: return 3'd4;
        default: return 3'd2;
      endcase
    end
    return (v.size > 3'd4) ? 3'd4 : v.size;
  endfunction

  function automatic logic [1:0] exp_mode(input vec_t v);
    if (v.is_c) return v.cinsn[5] ? 2'b01 : 2'b00;
    return v.mode;
  endfunction

  function automatic logic [4:0] exp_dest(input vec_t v, input int j);
    logic [4:0] d;
    d = v.is_c ? (5'd8 + {2'b00, v.cinsn[4:2]}) : v.dest;
    return d + 5'(j);
  endfunction

  function automatic logic [31:0] exp_addr(input vec_t v, input int j);
    logic [31:0] off;
    off = v.is_c ? {26'd0, v.cinsn[12:10], v.cinsn[6], 2'b00}
                 : {{20{v.off[11]}}, v.off};
    case (exp_mode(v))
      2'b10:   return v.base + off + idx_of(j);
      2'b01:   return v.base + off + 32'(j) * v.stride;
      default: return v.base + off + 32'(j) * (32'd1 << exp_size(v));
    endcase
  endfunction

  task automatic drive_cmd(input vec_t v);
    cmd_is_c   = v.is_c;
    cmd_cinsn  = v.cinsn;
    cmd_mode   = v.mode;
    cmd_size   = v.size;
    cmd_offset = v.off;
    cmd_dest   = v.dest;
    cmd_base   = v.base;
    cmd_stride = v.stride;
    cmd_vlen   = v.vlen;
  endtask

  // issue one command and follow it to completion; called at a negedge
  task automatic run_vec(input vec_t v, input bit noisy, input string tag);
    cmd_valid = 1'b1;
    drive_cmd(v);
    #1;
    chk("R1", {tag, " ready before issue"}, 32'(cmd_ready), 32'd1);
    @(negedge clk);
    cmd_valid = noisy;
    if (noisy) begin
      cmd_is_c = 1'b0; cmd_mode = 2'b01; cmd_base = 32'hDEAD_0000;
      cmd_stride = 32'h4; cmd_vlen = 7'd1; cmd_dest = 5'd17;
    end
    for (int j = 0; j < int'(v.vlen); j++) begin
      if (j % 2 == 1) begin
        req_ready = 1'b0;
        idx_value = idx_of(j);
        #1;
        chk("R8", {tag, " stall valid"}, 32'(req_valid), 32'd1);
        if (noisy) chk("R11", {tag, " busy not ready"}, 32'(cmd_ready), 32'd0);
        @(negedge clk);
        chk("R8", {tag, " stall elem hold"}, 32'(req_elem), 32'(j));
        chk("R8", {tag, " stall addr hold"}, req_addr, exp_addr(v, j));
      end
      req_ready = 1'b1;
      idx_value = idx_of(j);
      #1;
      chk("R8", {tag, " valid"}, 32'(req_valid), 32'd1);
      chk("R8", {tag, " elem"}, 32'(req_elem), 32'(j));
      chk(v.is_c ? "R6" : (exp_mode(v) == 2'b10 ? "R4" : "R2"),
          {tag, " addr"}, req_addr, exp_addr(v, j));
      chk(v.is_c ? "R7" : "R5", {tag, " size"}, 32'(req_size), 32'(exp_size(v)));
      chk(v.is_c ? "R6" : "R5", {tag, " reg"}, 32'(req_reg), 32'(exp_dest(v, j)));
      @(negedge clk);
    end
    req_ready = 1'b0;
    #1;
    chk(v.vlen == 0 ? "R10" : "R9", {tag, " done pulse"}, 32'(done), 32'd1);
    chk(v.vlen == 0 ? "R10" : "R8", {tag, " no extra req"}, 32'(req_valid), 32'd0);
    chk("R1", {tag, " not ready in done"}, 32'(cmd_ready), 32'd0);
    cmd_valid = 1'b0;
    @(negedge clk);
    #1;
    chk("R9", {tag, " done low"}, 32'(done), 32'd0);
    chk("R9", {tag, " ready back"}, 32'(cmd_ready), 32'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    vec_t z;
    rst_n = 1'b0; cmd_valid = 1'b0; req_ready = 1'b0; idx_value = '0;
    cmd_is_c = 1'b0; cmd_cinsn = '0; cmd_mode = '0; cmd_size = '0;
    cmd_offset = '0; cmd_dest = '0; cmd_base = '0; cmd_stride = '0; cmd_vlen = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "reset ready", 32'(cmd_ready), 32'd1);
    chk("R12", "reset valid", 32'(req_valid), 32'd0);
    chk("R12", "reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0, $sformatf("vec%0d", i));

    // R11: command traffic while busy, with stalls on odd elements
    run_vec(VECS[1], 1'b1, "busy_r11");
    run_vec(VECS[2], 1'b1, "busy_idx_r11");

    // R10: empty command
    z = VECS[0];
    z.vlen = 7'd0;
    run_vec(z, 1'b0, "empty_r10");

    // R12: asynchronous reset in the middle of a command
    cmd_valid = 1'b1;
    drive_cmd(VECS[0]);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    chk("R12", "busy before reset", 32'(req_valid), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R12", "mid reset valid", 32'(req_valid), 32'd0);
    chk("R12", "mid reset ready", 32'(cmd_ready), 32'd1);
    chk("R12", "mid reset done", 32'(done), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(VECS[3], 1'b0, "after_reset_r12");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule